// File: doc/BRIEF.md
# Scatter-Gather Descriptor DMA Engine

This engine moves one device-side buffer to or from a set of memory regions. The regions are listed in a table of descriptors held in memory. A start pulse latches the table base, the buffer length in bytes and the direction. The engine then alternates between two activities. When the current region is used up, it reads the next descriptor over a read-only descriptor port. While the region still has bytes, it moves data in beats of up to four bytes over a second memory port that can read or write.

The device buffer sits outside the engine. The engine addresses it with a byte index, reads it through a combinational data input, and writes it through a strobed write output. Each transfer ends with a done flag and a complete flag. The complete flag tells whether the whole buffer moved or the descriptor table ran out first. After an incomplete transfer, a restart pulse walks the table again from its base. It keeps the bytes already moved and the device index.

Top module: `sgdma_engine`

## Requirements
- R1: After a synchronous reset the engine is idle: busy, done and complete are 0, dev_idx is 0, and neither memory port has a request raised.
- R2: A descriptor is two 32-bit words read from the descriptor port: the region address at the fetch pointer, then the size word at pointer+4. The pointer then stands 8 bytes further on.
- R3: The region length is the size word masked with 0xFFFE, so bit 0 of the size word has no effect on the bytes moved.
- R4: A masked length of zero stands for a region of 65536 bytes.
- R5: A size word with bit 31 set marks the final descriptor. Once that region is used up, no further descriptor is read.
- R6: Descriptor reads stop once the fetch pointer is 4096 or more bytes past the table base, even if no final marker has been seen.
- R7: Each data beat moves n = min(4, bytes left in the region, bytes left in the buffer) bytes, using the low n byte strobes. After the beat, the region address and dev_idx advance by n. A request is held with a stable address until it is acknowledged.
- R8: With dir=1 the device bytes at dev_idx are written to memory (mem_we=1). With dir=0 memory data is read and written into the device buffer through dev_wr.
- R9: When the buffer count reaches zero, the engine goes idle with done=1 and complete=1. When the table ends first, it goes idle with done=1 and complete=0.
- R10: A restart while idle after an incomplete transfer reloads the fetch pointer from the table base and clears the current region. It keeps dev_idx and the remaining count, so the transfer resumes where it stopped.
- R11: A start clears the current region address, length and final flag. It also sets dev_idx to 0 and loads the byte count, so a final flag left from a previous transfer has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new transfer (taken while idle) |
| restart | input | 1 | Re-walk the table after an incomplete transfer |
| dir | input | 1 | 1: device to memory, 0: memory to device |
| tbl_base | input | AW | Byte address of the descriptor table |
| xfer_bytes | input | CNTW | Device buffer length in bytes |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer has ended |
| complete | output | 1 | Last transfer moved the whole buffer |
| dsc_req | output | 1 | Descriptor word read request |
| dsc_addr | output | AW | Descriptor word byte address |
| dsc_ack | input | 1 | Descriptor read acknowledge, data valid |
| dsc_rdata | input | 32 | Descriptor word |
| mem_req | output | 1 | Data beat request |
| mem_we | output | 1 | Data beat is a write |
| mem_addr | output | AW | Data beat byte address |
| mem_be | output | 4 | Byte strobes, low n bytes |
| mem_wdata | output | 32 | Write data taken from the device |
| mem_ack | input | 1 | Data beat acknowledge, read data valid |
| mem_rdata | input | 32 | Read data from memory |
| dev_idx | output | CNTW | Device buffer byte index |
| dev_rdata | input | 32 | Device word at dev_idx |
| dev_wr | output | 1 | Write strobe into the device buffer |
| dev_wdata | output | 32 | Data for the device buffer |
| dev_be | output | 4 | Byte strobes for the device write |

## Verification
The bench keeps the default parameters: 32-bit addresses, a 17-bit byte count and a 4096-byte descriptor window. With a 17-bit count, a buffer larger than a full page of descriptors can be used. That makes it practical to fill 512 descriptors that carry no final marker and watch the engine stop at the page limit. The count also holds the 65536-byte value that a zero length decodes to, so a region of that size can be shown to outlast a short buffer. Memory and the device buffer are behavioural arrays, and their contents are compared against an independent scatter list.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH_ADDR,
    ST_FETCH_SIZE,
    ST_MOVE
  } sg_state_t;

  localparam int BEAT_BYTES = 4;
  localparam int DESC_BYTES = 8;
endpackage

// File: rtl/sgdma_desc_decode.sv
module sgdma_desc_decode #(
  parameter int CNTW = 17
) (
  input  logic [31:0]     size_word,
  output logic [CNTW-1:0] region_len,
  output logic            final_entry
);
  logic [15:0] masked;

  always_comb begin
    masked = size_word[15:0] & 16'hFFFE;
    if (masked == 16'd0) region_len = CNTW'(32'h0001_0000);
    else                 region_len = CNTW'(masked);
    final_entry = size_word[31];
  end
endmodule

// File: rtl/sgdma_beat_calc.sv
module sgdma_beat_calc #(
  parameter int CNTW = 17
) (
  input  logic [CNTW-1:0] region_left,
  input  logic [CNTW-1:0] buffer_left,
  output logic [2:0]      beat_n,
  output logic [3:0]      beat_be
);
  logic [CNTW-1:0] smaller;

  always_comb begin
    smaller = (region_left < buffer_left) ? region_left : buffer_left;
    if (smaller >= CNTW'(4)) beat_n = 3'd4;
    else                     beat_n = smaller[2:0];
    case (beat_n)
      3'd1:    beat_be = 4'b0001;
      3'd2:    beat_be = 4'b0011;
      3'd3:    beat_be = 4'b0111;
      default: beat_be = 4'b1111;
    endcase
  end
endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CNTW       = 17,
  parameter int PAGE_BYTES = 4096
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            restart,
  input  logic            dir,
  input  logic [AW-1:0]   tbl_base,
  input  logic [CNTW-1:0] xfer_bytes,
  output logic            busy,
  output logic            done,
  output logic            complete,
  output logic            dsc_req,
  output logic [AW-1:0]   dsc_addr,
  input  logic            dsc_ack,
  input  logic [31:0]     dsc_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [3:0]      mem_be,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata,
  output logic [CNTW-1:0] dev_idx,
  input  logic [31:0]     dev_rdata,
  output logic            dev_wr,
  output logic [31:0]     dev_wdata,
  output logic [3:0]      dev_be
);
  localparam logic [AW-1:0] PAGE_LIM = AW'(PAGE_BYTES);
  localparam logic [AW-1:0] WORD_STEP = AW'(DESC_BYTES / 2);

  sg_state_t       st;
  logic [AW-1:0]   base_q, ptr_q, reg_addr_q;
  logic [CNTW-1:0] reg_left_q, buf_left_q, idx_q;
  logic            last_q, dir_q, done_q, complete_q;

  logic [CNTW-1:0] dec_len;
  logic            dec_last;
  logic [2:0]      beat_n;
  logic [3:0]      beat_be;
  logic            table_end;

  sgdma_desc_decode #(.CNTW(CNTW)) u_dec (
    .size_word  (dsc_rdata),
    .region_len (dec_len),
    .final_entry(dec_last)
  );

  sgdma_beat_calc #(.CNTW(CNTW)) u_beat (
    .region_left(reg_left_q),
    .buffer_left(buf_left_q),
    .beat_n     (beat_n),
    .beat_be    (beat_be)
  );

  assign table_end = last_q || ((ptr_q - base_q) >= PAGE_LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      base_q     <= '0;
      ptr_q      <= '0;
      reg_addr_q <= '0;
      reg_left_q <= '0;
      buf_left_q <= '0;
      idx_q      <= '0;
      last_q     <= 1'b0;
      dir_q      <= 1'b0;
      done_q     <= 1'b0;
      complete_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            base_q     <= tbl_base;
            ptr_q      <= tbl_base;
            dir_q      <= dir;
            buf_left_q <= xfer_bytes;
            idx_q      <= '0;
            reg_addr_q <= '0;
            reg_left_q <= '0;
            last_q     <= 1'b0;
            done_q     <= 1'b0;
            complete_q <= 1'b0;
            st         <= ST_CHECK;
          end else if (restart && done_q && !complete_q) begin
            ptr_q      <= base_q;
            reg_addr_q <= '0;
            reg_left_q <= '0;
            last_q     <= 1'b0;
            done_q     <= 1'b0;
            st         <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (buf_left_q == '0) begin
            done_q     <= 1'b1;
            complete_q <= 1'b1;
            st         <= ST_IDLE;
          end else if (reg_left_q != '0) begin
            st <= ST_MOVE;
          end else if (table_end) begin
            done_q     <= 1'b1;
            complete_q <= 1'b0;
            st         <= ST_IDLE;
          end else begin
            st <= ST_FETCH_ADDR;
          end
        end
        ST_FETCH_ADDR: begin
          if (dsc_ack) begin
            reg_addr_q <= AW'(dsc_rdata);
            ptr_q      <= ptr_q + WORD_STEP;
            st         <= ST_FETCH_SIZE;
          end
        end
        ST_FETCH_SIZE: begin
          if (dsc_ack) begin
            reg_left_q <= dec_len;
            last_q     <= dec_last;
            ptr_q      <= ptr_q + WORD_STEP;
            st         <= ST_CHECK;
          end
        end
        ST_MOVE: begin
          if (mem_ack) begin
            reg_addr_q <= reg_addr_q + AW'(beat_n);
            reg_left_q <= reg_left_q - CNTW'(beat_n);
            buf_left_q <= buf_left_q - CNTW'(beat_n);
            idx_q      <= idx_q + CNTW'(beat_n);
            st         <= ST_CHECK;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign done      = done_q;
  assign complete  = complete_q;
  assign dsc_req   = (st == ST_FETCH_ADDR) || (st == ST_FETCH_SIZE);
  assign dsc_addr  = ptr_q;
  assign mem_req   = (st == ST_MOVE);
  assign mem_we    = dir_q;
  assign mem_addr  = reg_addr_q;
  assign mem_be    = beat_be;
  assign mem_wdata = dev_rdata;
  assign dev_idx   = idx_q;
  assign dev_wr    = (st == ST_MOVE) && mem_ack && !dir_q;
  assign dev_wdata = mem_rdata;
  assign dev_be    = beat_be;
endmodule

// File: rtl/sgdma_engine_chk.sv
module sgdma_engine_chk #(
  parameter int AW   = 32,
  parameter int CNTW = 17
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            done,
  input logic            dsc_req,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [AW-1:0]   mem_addr,
  input logic [3:0]      mem_be,
  input logic [CNTW-1:0] dev_idx,
  input logic            dev_wr
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!dsc_req && !mem_req)); // R1

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
    !(dsc_req && mem_req)); // R2

  AST_LOW_STROBES: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_be != 4'b0000 && ((mem_be & (mem_be + 4'd1)) == 4'b0000))); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R7

  AST_IDX_FORWARD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (dev_idx >= $past(dev_idx))); // R7

  AST_DEV_WR_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    dev_wr |-> (mem_req && mem_ack && !mem_we)); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
endmodule

bind sgdma_engine sgdma_engine_chk #(.AW(AW), .CNTW(CNTW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .done    (done),
  .dsc_req (dsc_req),
  .mem_req (mem_req),
  .mem_we  (mem_we),
  .mem_ack (mem_ack),
  .mem_addr(mem_addr),
  .mem_be  (mem_be),
  .dev_idx (dev_idx),
  .dev_wr  (dev_wr)
);

// File: tb/sgdma_engine_test.sv
module sgdma_engine_test;
  localparam int AW = 32;
  localparam int CNTW = 17;
  localparam int MEMW = 16384;

  logic            clk = 1'b0;
  logic            rst, start, restart, dir;
  logic [AW-1:0]   tbl_base;
  logic [CNTW-1:0] xfer_bytes;
  logic            busy, done, complete;
  logic            dsc_req, dsc_ack;
  logic [AW-1:0]   dsc_addr, mem_addr;
  logic [31:0]     dsc_rdata, mem_rdata, mem_wdata, dev_rdata, dev_wdata;
  logic            mem_req, mem_we, mem_ack, dev_wr;
  logic [3:0]      mem_be, dev_be;
  logic [CNTW-1:0] dev_idx;

  logic [31:0] mem [0:MEMW-1];
  logic [31:0] dev [0:1023];

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  sgdma_engine #(.AW(AW), .CNTW(CNTW), .PAGE_BYTES(4096)) uut (
    .clk(clk), .rst(rst), .start(start), .restart(restart), .dir(dir),
    .tbl_base(tbl_base), .xfer_bytes(xfer_bytes),
    .busy(busy), .done(done), .complete(complete),
    .dsc_req(dsc_req), .dsc_addr(dsc_addr), .dsc_ack(dsc_ack), .dsc_rdata(dsc_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dev_idx(dev_idx), .dev_rdata(dev_rdata), .dev_wr(dev_wr),
    .dev_wdata(dev_wdata), .dev_be(dev_be)
  );

  assign dev_rdata = dev[dev_idx[11:2]];

  // Memory model: acknowledge one cycle after each request.
  always @(posedge clk) begin
    if (rst) begin
      dsc_ack <= 1'b0;
      mem_ack <= 1'b0;
    end else begin
      dsc_ack   <= dsc_req && !dsc_ack;
      dsc_rdata <= mem[dsc_addr[15:2]];
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= mem[mem_addr[15:2]];
      if (mem_req && !mem_ack && mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[15:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
      if (dev_wr) begin
        for (int b = 0; b < 4; b++)
          if (dev_be[b]) dev[dev_idx[11:2]][8*b +: 8] <= dev_wdata[8*b +: 8];
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < MEMW; i++) mem[i] = 32'h0;
    for (int i = 0; i < 1024; i++) dev[i] = 32'hD000_0000 + i;
  endtask

  task automatic put_desc(input int base, input int n, input logic [31:0] a, input logic [31:0] s);
    mem[(base >> 2) + 2*n]     = a;
    mem[(base >> 2) + 2*n + 1] = s;
  endtask

  task automatic wait_done(input string req);
    int t = 0;
    @(negedge clk);
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL %s: watchdog, done never rose (actual 0 expected 1)", req);
    end
  endtask

  task automatic go(input int base, input int bytes, input logic d, input string req);
    @(negedge clk);
    tbl_base = AW'(base); xfer_bytes = CNTW'(bytes); dir = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(req);
  endtask

  task automatic t_reset();
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);
    check("R1 complete", 32'(complete), 0);
    check("R1 dev_idx", 32'(dev_idx), 0);
    check("R1 requests", 32'({dsc_req, mem_req}), 0);
  endtask

  task automatic t_write_mem();
    clear_all();
    put_desc(32'h8000, 0, 32'h1000, 32'h0000_0010);
    put_desc(32'h8000, 1, 32'h2000, 32'h8000_0010);
    go(32'h8000, 24, 1'b1, "R8");
    check("R9 complete", 32'(complete), 1);
    check("R7 dev_idx", 32'(dev_idx), 24);
    for (int k = 0; k < 4; k++) check("R8 region0", mem[(32'h1000 >> 2) + k], dev[k]);
    for (int k = 0; k < 2; k++) check("R2 region1", mem[(32'h2000 >> 2) + k], dev[4 + k]);
    check("R7 beyond buffer", mem[(32'h2008 >> 2)], 32'h0);
  endtask

  task automatic t_read_mem();
    clear_all();
    for (int k = 0; k < 4; k++) mem[(32'h3000 >> 2) + k] = 32'hA500_0000 + k;
    for (int k = 0; k < 4; k++) mem[(32'h3800 >> 2) + k] = 32'h5A00_0000 + k;
    put_desc(32'h9000, 0, 32'h3000, 32'h0000_0008);
    put_desc(32'h9000, 1, 32'h3800, 32'h8000_0100);
    go(32'h9000, 20, 1'b0, "R8");
    check("R9 complete rd", 32'(complete), 1);
    check("R8 dev0", dev[0], 32'hA500_0000);
    check("R8 dev1", dev[1], 32'hA500_0001);
    check("R8 dev2", dev[2], 32'h5A00_0000);
    check("R8 dev4", dev[4], 32'h5A00_0002);
    check("R8 dev5 untouched", dev[5], 32'hD000_0005);
    check("R8 memory untouched", mem[(32'h3000 >> 2)], 32'hA500_0000);
  endtask

  task automatic t_table_ends();
    clear_all();
    put_desc(32'hA000, 0, 32'h4000, 32'h8000_0010);
    go(32'hA000, 64, 1'b1, "R5");
    check("R9 incomplete", 32'(complete), 0);
    check("R5 dev_idx", 32'(dev_idx), 16);
    check("R5 no next", mem[(32'h4010 >> 2)], 32'h0);
    // restart on a rewritten table resumes the same buffer
    put_desc(32'hA000, 0, 32'h5000, 32'h8000_0030);
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    wait_done("R10");
    check("R10 complete", 32'(complete), 1);
    check("R10 dev_idx", 32'(dev_idx), 64);
    check("R10 first resumed", mem[(32'h5000 >> 2)], dev[4]);
    check("R10 last resumed", mem[(32'h5000 >> 2) + 11], dev[15]);
  endtask

  task automatic t_new_start_clears();
    // the previous transfer left the final flag set; a new start ignores it
    clear_all();
    put_desc(32'hB000, 0, 32'h6000, 32'h0000_0004);
    put_desc(32'hB000, 1, 32'h6100, 32'h8000_0004);
    go(32'hB000, 8, 1'b1, "R11");
    check("R11 complete", 32'(complete), 1);
    check("R11 dev_idx", 32'(dev_idx), 8);
    check("R11 second region", mem[(32'h6100 >> 2)], dev[1]);
  endtask

  task automatic t_mask_bit0();
    clear_all();
    put_desc(32'hC000, 0, 32'h7000, 32'h8000_0009);
    go(32'hC000, 12, 1'b1, "R3");
    check("R3 incomplete", 32'(complete), 0);
    check("R3 dev_idx", 32'(dev_idx), 8);
    check("R3 word after", mem[(32'h7008 >> 2)], 32'h0);
  endtask

  task automatic t_zero_len();
    clear_all();
    put_desc(32'hC800, 0, 32'h7800, 32'h8000_0000);
    go(32'hC800, 32, 1'b1, "R4");
    check("R4 complete", 32'(complete), 1);
    check("R4 dev_idx", 32'(dev_idx), 32);
    check("R4 last word", mem[(32'h7800 >> 2) + 7], dev[7]);
  endtask

  task automatic t_page_limit();
    clear_all();
    for (int i = 0; i < 600; i++) put_desc(32'hD000, i, 32'h3000, 32'h0000_0004);
    go(32'hD000, 4096, 1'b1, "R6");
    check("R6 incomplete", 32'(complete), 0);
    check("R6 dev_idx", 32'(dev_idx), 2048);
    check("R6 last data", mem[(32'h3000 >> 2)], dev[511]);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; restart = 1'b0; dir = 1'b0;
    tbl_base = '0; xfer_bytes = '0;
    clear_all();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_mem();
    t_read_mem();
    t_table_ends();
    t_new_start_clears();
    t_mask_bit0();
    t_zero_len();
    t_page_limit();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1500000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish (actual hung expected finished)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule